// File: doc/BRIEF.md
# Three-Way Soft Arbiter

This block shares a resource among three clients, called a, b and c, with request bits 0, 1 and 2. The resource tolerates being briefly over-committed. Rather than a full 1-of-3 arbiter, it ranks the three requests two at a time. Three small pair cells handle a/b, a/c and b/c. In each cell the earlier arrival wins, and the winner is kept until both requests of that pair have gone low.

The grants are formed from the six pairwise outcomes:

- Client a is granted if it won either of its pairs.
- Client b is granted only if it won both of its pairs.
- Client c is granted only if it won both of its pairs.

Because a needs only one win, two grants can be given at once in some arrival orders. This cheap logic therefore over-grants now and then, which the resource can absorb.

Requests that arrive in the same cycle are settled by a fixed priority chosen by a parameter. Grants are registered: each one follows the request pattern sampled one clock edge earlier.

Top module: `soft_arb3`

## Requirements
- R1: While reset is asserted, and at the first edge after it, all three grant bits are 0.
- R2: A request that rises alone, while the other two are low, is granted after exactly one clock edge. Grant bit i belongs to request bit i (a=0, b=1, c=2).
- R3: Grant a is 1 when a is requesting and a arrived before b or before c.
- R4: Grant b requires b to have arrived before both a and c, and grant c requires c to have arrived before both a and b. Grants b and c are never 1 together.
- R5: The arrival order b, a, c gives grants a and b. The order c, a, b gives grants a and c.
- R6: The orders a,b,c, a,c,b, b,c,a and c,b,a each give a single grant, to the first arriver.
- R7: Requests of one pair that rise in the same cycle are settled by fixed priority. With TIE_LOWER_WINS=1 (the default) the lower request index wins. If all three rise together, only a is granted.
- R8: A grant falls at the first clock edge after its request is sampled low. No grant is ever 1 unless its request was high at the previous edge.
- R9: A pair keeps its winner while either of its requests is high, and it forgets the winner once both are low. A loser is re-ranked only when its request rises again after that reset.
- R10: At most two grants are 1 at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 3 | Requests: bit 0 = a, bit 1 = b, bit 2 = c |
| gnt_o | output | 3 | Registered grants, same bit order as req_i |

## Verification
Directed sequences raise the three requests one cycle apart in all six orders. This separates the two over-granting orders from the four single-grant ones, and shows that grant a uses an OR of its wins while b and c use an AND. Same-cycle arrivals of each pair, and of all three requests, exercise the tie priority. Drop-and-re-raise sequences show that a pair keeps its winner while one of its requests is still high, and that a dropped grant falls one edge later. A long seeded random stream, with bits toggling a quarter of the time, compares every cycle against a reference model built from pairwise arrival order. This covers overlapping and partial orders that the directed cases do not reach.

// File: rtl/soft_arb_pkg.sv
package soft_arb_pkg;

    localparam int NUM_CLIENTS = 3;
    localparam int NUM_PAIRS   = 3;

    typedef enum logic [1:0] {
        PAIR_OPEN     = 2'd0,
        PAIR_LO_AHEAD = 2'd1,
        PAIR_HI_AHEAD = 2'd2
    } pair_state_e;

    // Pair p ranks clients pair_lo(p) and pair_hi(p): 0=(a,b) 1=(a,c) 2=(b,c)
    function automatic int pair_lo(input int p);
        return (p == 2) ? 1 : 0;
    endfunction

    function automatic int pair_hi(input int p);
        return (p == 0) ? 1 : 2;
    endfunction

endpackage

// File: rtl/soft_arb_pair.sv
module soft_arb_pair
    import soft_arb_pkg::*;
#(
    parameter bit TIE_LOWER_WINS = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_lo,
    input  logic req_hi,
    output logic win_lo_nx,
    output logic win_hi_nx
);

    pair_state_e state_q;
    pair_state_e state_d;

    // Next-state: first arrival takes the pair, held until both drop
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PAIR_OPEN: begin
                if (req_lo && req_hi)
                    state_d = TIE_LOWER_WINS ? PAIR_LO_AHEAD : PAIR_HI_AHEAD;
                else if (req_lo)
                    state_d = PAIR_LO_AHEAD;
                else if (req_hi)
                    state_d = PAIR_HI_AHEAD;
                else
                    state_d = PAIR_OPEN;
            end
            PAIR_LO_AHEAD,
            PAIR_HI_AHEAD: begin
                if (!req_lo && !req_hi)
                    state_d = PAIR_OPEN;
            end
            default: state_d = PAIR_OPEN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= PAIR_OPEN;
        else
            state_q <= state_d;
    end

    always_comb begin
        win_lo_nx = (state_d == PAIR_LO_AHEAD);
        win_hi_nx = (state_d == PAIR_HI_AHEAD);
    end

    // R9: decision held while either request is high
    p_pair_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != PAIR_OPEN && (req_lo || req_hi)) |=> (state_q == $past(state_q)));

    // R9: both low clears the pair
    p_pair_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_lo && !req_hi) |=> (state_q == PAIR_OPEN));

    // R10: one winner per pair
    p_pair_one_winner_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({win_lo_nx, win_hi_nx}));

endmodule

// File: rtl/soft_arb_grant.sv
module soft_arb_grant
    import soft_arb_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_CLIENTS-1:0] req,
    input  logic [NUM_PAIRS-1:0]   win_lo,
    input  logic [NUM_PAIRS-1:0]   win_hi,
    output logic [NUM_CLIENTS-1:0] gnt_q
);

    logic [NUM_CLIENTS-1:0] gnt_d;
    logic a_over_b, a_over_c, b_over_a, b_over_c, c_over_a, c_over_b;

    always_comb begin
        a_over_b = win_lo[0];
        b_over_a = win_hi[0];
        a_over_c = win_lo[1];
        c_over_a = win_hi[1];
        b_over_c = win_lo[2];
        c_over_b = win_hi[2];
        // Soft rule: a takes either win, b and c need both
        gnt_d[0] = req[0] && (a_over_b || a_over_c);
        gnt_d[1] = req[1] && b_over_a && b_over_c;
        gnt_d[2] = req[2] && c_over_a && c_over_b;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            gnt_q <= '0;
        else
            gnt_q <= gnt_d;
    end

    // R4: b and c never share a grant
    p_bc_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(gnt_q[1] && gnt_q[2]));

endmodule

// File: rtl/soft_arb3.sv
module soft_arb3
    import soft_arb_pkg::*;
#(
    parameter bit TIE_LOWER_WINS = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] req_i,
    output logic [2:0] gnt_o
);

    logic [NUM_PAIRS-1:0] win_lo;
    logic [NUM_PAIRS-1:0] win_hi;

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        localparam int LO = pair_lo(p);
        localparam int HI = pair_hi(p);
        soft_arb_pair #(
            .TIE_LOWER_WINS(TIE_LOWER_WINS)
        ) u_pair (
            .clk      (clk),
            .rst_n    (rst_n),
            .req_lo   (req_i[LO]),
            .req_hi   (req_i[HI]),
            .win_lo_nx(win_lo[p]),
            .win_hi_nx(win_hi[p])
        );
    end

    soft_arb_grant u_grant (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req_i),
        .win_lo(win_lo),
        .win_hi(win_hi),
        .gnt_q (gnt_o)
    );

    // R8: no grant without its request one edge earlier
    p_grant_needs_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((gnt_o & ~$past(req_i)) == 3'b000));

    // R10: never more than two grants
    p_two_max_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(gnt_o) <= 2));

    // R2: a lone fresh request is granted next edge
    p_lone_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(req_i) == 3'b000 && $onehot(req_i)) |=> (gnt_o == $past(req_i)));

endmodule

// File: tb/soft_arb3_tb.sv
module soft_arb3_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] req = 3'b000;
    logic [2:0] gnt;

    int checks = 0;
    int errors = 0;
    int m_st [3];   // 0 open, 1 lower won, 2 higher won
    localparam bit TIE_LO = 1'b1;

    always #5 clk = ~clk;

    soft_arb3 u_dut (.clk(clk), .rst_n(rst_n), .req_i(req), .gnt_o(gnt));

    function automatic int nxt(input int s, input logic lo, input logic hi);
        if (s == 0) begin
            if (lo && hi) return TIE_LO ? 1 : 2;
            if (lo) return 1;
            if (hi) return 2;
            return 0;
        end
        return (lo || hi) ? s : 0;
    endfunction

    function automatic logic [2:0] grants(input logic [2:0] r);
        logic [2:0] g;
        g[0] = r[0] && (m_st[0] == 1 || m_st[1] == 1);
        g[1] = r[1] && m_st[0] == 2 && m_st[2] == 1;
        g[2] = r[2] && m_st[1] == 2 && m_st[2] == 2;
        return g;
    endfunction

    task automatic check(input logic [2:0] exp, input string tag);
        checks++;
        if (gnt !== exp) begin
            errors++;
            $display("FAIL %s: gnt=%b expected=%b", tag, gnt, exp);
        end
    endtask

    // drive one cycle, update model, compare after the edge
    task automatic cyc(input logic [2:0] v, input string tag, input bit chk);
        logic [2:0] exp;
        @(negedge clk);
        req = v;
        @(posedge clk);
        m_st[0] = nxt(m_st[0], v[0], v[1]);
        m_st[1] = nxt(m_st[1], v[0], v[2]);
        m_st[2] = nxt(m_st[2], v[1], v[2]);
        exp = grants(v);
        #1;
        if (chk) check(exp, tag);
        checks++;
        if ($countones(gnt) > 2 || (gnt[1] && gnt[2])) begin
            errors++;
            $display("FAIL R10: gnt=%b expected at most two and not b+c", gnt);
        end
    endtask

    task automatic order3(input int f, input int s, input int t,
                          input logic [2:0] exp, input string tag);
        logic [2:0] v;
        cyc(3'b000, tag, 1'b0);
        v = 3'b000; v[f] = 1'b1;
        cyc(v, tag, 1'b1);
        v[s] = 1'b1;
        cyc(v, tag, 1'b1);
        v[t] = 1'b1;
        cyc(v, tag, 1'b1);
        check(exp, tag);
    endtask

    initial begin
        logic [2:0] r;
        int seed;
        for (int i = 0; i < 3; i++) m_st[i] = 0;
        repeat (3) @(posedge clk);
        #1 check(3'b000, "R1 in reset");
        @(negedge clk) rst_n = 1'b1;
        cyc(3'b000, "R1 after reset", 1'b1);
        check(3'b000, "R1 first edge");

        // R2 lone requests
        cyc(3'b001, "R2 lone a", 1'b1); check(3'b001, "R2 lone a");
        cyc(3'b000, "R8 a dropped", 1'b1); check(3'b000, "R8 a dropped");
        cyc(3'b010, "R2 lone b", 1'b1); check(3'b010, "R2 lone b");
        cyc(3'b000, "R8", 1'b1);
        cyc(3'b100, "R2 lone c", 1'b1); check(3'b100, "R2 lone c");

        // R5 / R6 / R3 / R4 all six orders
        order3(1, 0, 2, 3'b011, "R5 order b,a,c");
        order3(2, 0, 1, 3'b101, "R5 order c,a,b");
        order3(0, 1, 2, 3'b001, "R6 order a,b,c");
        order3(0, 2, 1, 3'b001, "R6 R3 order a,c,b");
        order3(1, 2, 0, 3'b010, "R6 R4 order b,c,a");
        order3(2, 1, 0, 3'b100, "R6 R4 order c,b,a");

        // R3: a beats only c (b first, c absent then c later)
        cyc(3'b000, "R3", 1'b0);
        cyc(3'b010, "R3", 1'b1);
        cyc(3'b011, "R3 a after b, c absent", 1'b1); check(3'b011, "R3 a over c");

        // R7 ties
        cyc(3'b000, "R7", 1'b0);
        cyc(3'b111, "R7 all same cycle", 1'b1); check(3'b001, "R7 all same cycle");
        cyc(3'b000, "R7", 1'b0);
        cyc(3'b110, "R7 b,c same cycle", 1'b1); check(3'b010, "R7 b,c tie");

        // R9: a wins ab, a drops while b held -> b stays ungranted
        cyc(3'b000, "R9", 1'b0);
        cyc(3'b001, "R9", 1'b1);
        cyc(3'b011, "R9", 1'b1);
        cyc(3'b010, "R9 loser held", 1'b1); check(3'b000, "R9 loser held");
        cyc(3'b011, "R9 a re-raised keeps win", 1'b1); check(3'b001, "R9 a re-raised");
        cyc(3'b000, "R9 both low", 1'b1); check(3'b000, "R8 R9 both low");
        cyc(3'b010, "R9 b re-arrives", 1'b1); check(3'b010, "R9 b re-arrives");

        // random stream
        seed = 32'h5eed;
        void'($urandom(seed));
        r = 3'b000;
        for (int n = 0; n < 4000; n++) begin
            for (int b = 0; b < 3; b++)
                if ($urandom_range(3) == 0) r[b] = ~r[b];
            cyc(r, "R10 random", 1'b1);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule